// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides an N-bit dividend by an N-bit divisor over several clock cycles. It produces one quotient bit per iteration. All of the work happens in a single 2N-bit partial-remainder register. The dividend is loaded into the lower half and the upper half starts at zero. On each iteration the register shifts left by one bit and a trial subtraction of the divisor is made against the upper half. A successful subtraction is kept and writes a 1 into the bit that the shift just vacated. A failed one leaves the upper half as it was before the trial. After N iterations the lower half holds the quotient and the upper half holds the remainder.

A mode input selects unsigned or two's-complement division. In signed mode both operands are first reduced to magnitudes and then divided unsigned. After the loop, the quotient is negated if the operand signs differed, and the remainder takes the sign of the dividend. A zero divisor is flagged, with defined result values. A one-cycle start pulse launches an operation and a one-cycle done pulse marks the result. The results stay on the outputs until the next operation completes.

Top module: `seq_restoring_divider`

## Requirements
- R1: While reset is asserted, and after it until the first completion, done_o and div_zero_o are 0 and quotient_o and remainder_o are all zeros.
- R2: With signed_i = 0 and a nonzero divisor, quotient_o = floor(dividend / divisor) and remainder_o = dividend mod divisor, both unsigned. This includes operands whose top bit is set.
- R3: With signed_i = 1 and a nonzero divisor, the operands are read as two's complement. quotient_o is the quotient truncated toward zero: its magnitude is |dividend| / |divisor|, and it is negative exactly when the operand signs differ.
- R4: With signed_i = 1 and a nonzero divisor, remainder_o equals dividend - quotient * divisor. It is zero or has the sign of the dividend, and its magnitude is below |divisor|.
- R5: A start_i sampled high at a rising edge while the block is idle is accepted. done_o is then high for exactly one cycle, the one that follows the (N+1)-th rising edge after the accepting edge.
- R6: A start_i raised while an operation is in progress is ignored, whatever the operands. The running operation finishes on its own schedule with its own result.
- R7: A zero divisor, in either mode, gives div_zero_o = 1 together with done_o, quotient_o = all ones and remainder_o = the dividend unchanged. A nonzero divisor gives div_zero_o = 0.
- R8: quotient_o, remainder_o and div_zero_o keep their values between completions, whatever the inputs do.
- R9: In signed mode, the most negative dividend divided by -1 gives the most negative value as quotient (the bit pattern 1 followed by N-1 zeros) and a remainder of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | WIDTH | Dividend, sampled at the accepting edge |
| divisor_i | input | WIDTH | Divisor, sampled at the accepting edge |
| quotient_o | output | WIDTH | Quotient of the last completed operation |
| remainder_o | output | WIDTH | Remainder of the last completed operation |
| done_o | output | 1 | One-cycle pulse when a result is written |
| div_zero_o | output | 1 | Last completed operation had a zero divisor |

## Verification
The bench uses a 5-bit configuration and sweeps every dividend against every divisor in both modes. Unsigned operands with the top bit set test the widened trial subtraction: a divider that compares in only N bits gets these wrong. In signed mode, the four combinations of operand signs separate quotient negation from remainder sign correction, and the most-negative-by-minus-one pair exposes overflow handling. The zero-divisor column is covered in both modes. Directed sequences then check the done latency, a second start issued in the middle of an operation, and that results are held over idle cycles while the inputs keep changing.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
  parameter int WIDTH = 16
) (
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] mag_dvd_o,
  output logic [WIDTH-1:0] mag_dvs_o,
  output logic             neg_quo_o,
  output logic             neg_rem_o,
  output logic             zero_dvs_o
);
  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v, input logic neg);
    return neg ? (~v + WIDTH'(1)) : v;
  endfunction

  logic dvd_neg, dvs_neg;
  assign dvd_neg    = signed_i & dividend_i[WIDTH-1];
  assign dvs_neg    = signed_i & divisor_i[WIDTH-1];
  assign mag_dvd_o  = magnitude(dividend_i, dvd_neg);
  assign mag_dvs_o  = magnitude(divisor_i, dvs_neg);
  assign neg_quo_o  = dvd_neg ^ dvs_neg;
  assign neg_rem_o  = dvd_neg;
  assign zero_dvs_o = (divisor_i == '0);
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int WIDTH = 16
) (
  input  logic [2*WIDTH-1:0] part_i,
  input  logic [WIDTH-1:0]   dvs_i,
  output logic [2*WIDTH-1:0] part_o,
  output logic               bit_set_o
);
  localparam int TW = WIDTH + 1;

  // Upper half after the left shift, with the bit shifted out kept as an extra MSB.
  function automatic logic [TW-1:0] shifted_top(input logic [2*WIDTH-1:0] p);
    return {p[2*WIDTH-1:WIDTH], p[WIDTH-1]};
  endfunction

  logic [TW-1:0] top_w;
  logic [TW-1:0] trial_w;
  logic          fits_w;

  assign top_w     = shifted_top(part_i);
  assign trial_w   = top_w - {1'b0, dvs_i};
  assign fits_w    = ~trial_w[TW-1];
  assign bit_set_o = fits_w;
  assign part_o    = {(fits_w ? trial_w[WIDTH-1:0] : top_w[WIDTH-1:0]),
                      part_i[WIDTH-2:0], fits_w};
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] quo_mag_i,
  input  logic [WIDTH-1:0] rem_mag_i,
  input  logic             neg_quo_i,
  input  logic             neg_rem_i,
  input  logic             zero_dvs_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  function automatic logic [WIDTH-1:0] apply_sign(input logic [WIDTH-1:0] v, input logic neg);
    return neg ? (~v + WIDTH'(1)) : v;
  endfunction

  // A zero divisor leaves the magnitude of the dividend in the upper half,
  // so only the quotient needs forcing.
  assign quo_o = zero_dvs_i ? '1 : apply_sign(quo_mag_i, neg_quo_i);
  assign rem_o = apply_sign(rem_mag_i, neg_rem_i);
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  div_state_e    state_q;
  logic [CW-1:0] iter_q;

  assign accept_o = (state_q == DIV_IDLE) & start_i;
  assign step_o   = (state_q == DIV_RUN);
  assign finish_o = (state_q == DIV_FIX);
  assign busy_o   = (state_q != DIV_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      iter_q  <= '0;
    end else begin
      unique case (state_q)
        DIV_IDLE: if (start_i) begin
          state_q <= DIV_RUN;
          iter_q  <= '0;
        end
        DIV_RUN: begin
          iter_q <= iter_q + CW'(1);
          if (iter_q == LAST) state_q <= DIV_FIX;
        end
        DIV_FIX: state_q <= DIV_IDLE;
        default: state_q <= DIV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             done_o,
  output logic             div_zero_o
);
  localparam int PW = 2 * WIDTH;

  // named internal events
  logic accept, step_en, finish, busy, bit_set;

  logic [WIDTH-1:0] mag_dvd, mag_dvs;
  logic             neg_quo, neg_rem, zero_dvs;
  logic [PW-1:0]    part_q, part_nxt;
  logic [WIDTH-1:0] dvs_q;
  logic             neg_quo_q, neg_rem_q, dbz_q;
  logic [WIDTH-1:0] fix_quo, fix_rem;
  logic [WIDTH-1:0] part_hi;

  assign part_hi = part_q[PW-1:WIDTH];

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .accept_o(accept), .step_o(step_en), .finish_o(finish), .busy_o(busy)
  );

  div_sign_prep #(.WIDTH(WIDTH)) u_prep (
    .signed_i(signed_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
    .mag_dvd_o(mag_dvd), .mag_dvs_o(mag_dvs),
    .neg_quo_o(neg_quo), .neg_rem_o(neg_rem), .zero_dvs_o(zero_dvs)
  );

  div_restore_step #(.WIDTH(WIDTH)) u_step (
    .part_i(part_q), .dvs_i(dvs_q), .part_o(part_nxt), .bit_set_o(bit_set)
  );

  div_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .quo_mag_i(part_q[WIDTH-1:0]), .rem_mag_i(part_hi),
    .neg_quo_i(neg_quo_q), .neg_rem_i(neg_rem_q), .zero_dvs_i(dbz_q),
    .quo_o(fix_quo), .rem_o(fix_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q    <= '0;
      dvs_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      dbz_q     <= 1'b0;
    end else if (accept) begin
      part_q    <= {{WIDTH{1'b0}}, mag_dvd};
      dvs_q     <= mag_dvs;
      neg_quo_q <= neg_quo;
      neg_rem_q <= neg_rem;
      dbz_q     <= zero_dvs;
    end else if (step_en) begin
      part_q <= part_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient_o  <= '0;
      remainder_o <= '0;
      div_zero_o  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) begin
        quotient_o  <= fix_quo;
        remainder_o <= fix_rem;
        div_zero_o  <= dbz_q;
      end
    end
  end
endmodule

// File: rtl/div_chk.sv
module div_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             signed_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic             done_o,
  input logic             div_zero_o,
  input logic             accept,
  input logic             busy,
  input logic             dbz_q,
  input logic [WIDTH-1:0] dvs_q,
  input logic [WIDTH-1:0] part_hi
);
  localparam int LW = $clog2(WIDTH + 3) + 1;
  localparam logic [LW-1:0] LMAX = '1;
  localparam int PW = 2 * WIDTH;

  logic [LW-1:0]    lat_q;
  logic [WIDTH-1:0] cap_a, cap_b;
  logic             cap_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= LMAX;
      cap_a <= '0;
      cap_b <= '0;
      cap_s <= 1'b0;
    end else if (accept) begin
      lat_q <= '0;
      cap_a <= dividend_i;
      cap_b <= divisor_i;
      cap_s <= signed_i;
    end else if (lat_q != LMAX) begin
      lat_q <= lat_q + LW'(1);
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == LW'(WIDTH + 1)));

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(dvs_q) && !accept);

  // R2
  partial_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dbz_q) |-> (part_hi < dvs_q));

  // R7
  zero_divisor_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && div_zero_o) |-> ((&quotient_o) && (remainder_o == cap_a)));

  // R2
  unsigned_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cap_s && (cap_b != '0)) |->
      ((PW'(quotient_o) * PW'(cap_b) + PW'(remainder_o) == PW'(cap_a))
       && (remainder_o < cap_b)));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o));
endmodule

bind seq_restoring_divider div_chk #(.WIDTH(WIDTH)) u_div_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
  .dividend_i(dividend_i), .divisor_i(divisor_i),
  .quotient_o(quotient_o), .remainder_o(remainder_o),
  .done_o(done_o), .div_zero_o(div_zero_o),
  .accept(accept), .busy(busy), .dbz_q(dbz_q), .dvs_q(dvs_q), .part_hi(part_hi)
);

// File: tb/tb_seq_restoring_divider.sv
`timescale 1ns/1ps
module tb_seq_restoring_divider;
  localparam int N = 5;
  localparam int M = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [N-1:0] dividend_i = '0;
  logic [N-1:0] divisor_i = '0;
  logic [N-1:0] quotient_o, remainder_o;
  logic         done_o, div_zero_o;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  seq_restoring_divider #(.WIDTH(N)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .done_o(done_o), .div_zero_o(div_zero_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v >= M / 2) ? v - M : v;
  endfunction

  function automatic void model(input int a, input int b, input bit s,
                                output int q, output int r, output bit z);
    int sa, sb;
    if (b == 0) begin
      q = M - 1; r = a; z = 1'b1;
    end else if (!s) begin
      q = a / b; r = a % b; z = 1'b0;
    end else begin
      sa = to_signed(a); sb = to_signed(b);
      q = (sa / sb) & (M - 1);
      r = (sa % sb) & (M - 1);
      z = 1'b0;
    end
  endfunction

  task automatic launch(input int a, input int b, input bit s);
    @(negedge clk);
    dividend_i = N'(a); divisor_i = N'(b); signed_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    tests++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc, eq, er;
    bit ez;
    string tag;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(done_o == 0 && div_zero_o == 0, "R1", "flags in reset", {done_o, div_zero_o}, 0);
    check(quotient_o == 0 && remainder_o == 0, "R1", "results in reset",
          {quotient_o, remainder_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done_o == 0 && quotient_o == 0 && remainder_o == 0 && div_zero_o == 0,
          "R1", "idle after reset", {done_o, quotient_o, remainder_o}, 0);

    // R5 latency, directed
    launch(27, 4, 1'b0);
    wait_done(cyc);
    check(cyc == N + 1, "R5", "done latency", cyc, N + 1);
    @(negedge clk);
    check(done_o == 0, "R5", "done one cycle", done_o, 0);

    // exhaustive sweep in both modes
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < M; a++) begin
        for (int b = 0; b < M; b++) begin
          model(a, b, s[0], eq, er, ez);
          if (b == 0) tag = "R7";
          else if (s == 0) tag = "R2";
          else if (to_signed(a) == -(M / 2) && to_signed(b) == -1) tag = "R9";
          else tag = "R3/R4";
          launch(a, b, s[0]);
          wait_done(cyc);
          check(quotient_o == N'(eq), tag, "quotient", quotient_o, eq);
          check(remainder_o == N'(er), tag, "remainder", remainder_o, er);
          check(div_zero_o == ez, tag, "div_zero flag", div_zero_o, ez);
        end
      end
    end

    // R9 directed: most negative / -1
    launch(M / 2, M - 1, 1'b1);
    wait_done(cyc);
    check(quotient_o == N'(M / 2) && remainder_o == 0, "R9", "min/-1",
          {quotient_o, remainder_o}, (M / 2) << N);

    // R6 start while busy is ignored
    launch(20, 3, 1'b0);
    @(negedge clk);
    dividend_i = 7; divisor_i = 2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(cyc);
    check(cyc == N - 1, "R6", "original schedule kept", cyc, N - 1);
    check(quotient_o == 6 && remainder_o == 2, "R6", "first operation result",
          {quotient_o, remainder_o}, (6 << N) | 2);
    repeat (N + 3) @(negedge clk);
    check(quotient_o == 6 && remainder_o == 2 && done_o == 0, "R6",
          "no second completion", {done_o, quotient_o, remainder_o}, (6 << N) | 2);

    // R8 results held while inputs wander
    launch(9, 0, 1'b1);
    wait_done(cyc);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      dividend_i = N'(k * 7 + 3); divisor_i = N'(k + 1); signed_i = k[0];
    end
    check(done_o == 0, "R8", "no done while idle", done_o, 0);
    check(quotient_o == N'(M - 1) && remainder_o == 9 && div_zero_o == 1, "R8",
          "held results", {div_zero_o, quotient_o, remainder_o},
          (1 << (2 * N)) | ((M - 1) << N) | 9);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule